// File: doc/BRIEF.md
# Oversampled Averaging Period Meter

This block measures the period of a slow square wave that has no clock of its own. A much faster system clock samples the wave. The block counts system-clock cycles across a run of consecutive input periods. The length of that run is a power of two, chosen by a log2 select. The mean period therefore falls out of the accumulated count as a fixed-point value, with the binary point set by the select, so no divider is needed. The intended input range is 1 to 4 MHz against a 200 MHz sampling clock, which gives 50 to 200 cycles per period. The input may wander by a few percent.

Measurement runs continuously, so a drifting frequency is followed window after window. Each result appears with a one-cycle strobe. A convenience output shifts the sum right by the select to give the integer part of the mean. When the input stops toggling for longer than a programmable number of cycles, a no-signal flag goes high and the measurement starts over.

Top module: `period_meter`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_o and nosig_o are 0, and sum_o and mean_o are 0.
- R2: sig_i passes through two synchronizing flops, and a third flop detects its rising edge. A rise driven just after a falling clock edge is acted on at the third following rising clock edge. When that rise closes a window, valid_o is seen high after that same third edge.
- R3: The first rising edge after reset, or after a timeout, only opens a window and posts no result.
- R4: A posted sum_o equals the number of clock cycles between the edge that opened the window and the edge that closed it. The window spans 2^k input periods, where k is the effective select.
- R5: valid_o is high for exactly one cycle per closed window. sum_o and mean_o change only together with valid_o and hold otherwise.
- R6: The edge that closes a window also opens the next one, so consecutive windows leave no gap.
- R7: The select is captured when a window opens. A change during a window takes effect only in the following window.
- R8: log2n_i is 4 bits wide. Any value above LOG2N_MAX (default 8) acts as LOG2N_MAX.
- R9: mean_o equals sum_o shifted right by the effective select of the window that was posted.
- R10: If TIMEOUT_CYC (default 512) consecutive cycles pass with no detected rising edge, nosig_o goes high and any open window is discarded.
- R11: nosig_o returns to 0 in the cycle after the next detected rising edge, and that edge opens a new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Asynchronous square wave to measure |
| log2n_i | input | 4 | log2 of the number of periods per window |
| sum_o | output | ACC_W (18) | Cycle count over the last closed window |
| mean_o | output | ACC_W (18) | Integer part of the mean period |
| valid_o | output | 1 | One-cycle strobe when a new result is posted |
| nosig_o | output | 1 | Input has stopped toggling |

## Verification
The assertions assume that detected rising edges are at least two cycles apart, which the synchronizer guarantees. They also assume that every measured period is no longer than TIMEOUT_CYC cycles, so that a posted sum stays between 2·2^k and TIMEOUT_CYC·2^k. The stimulus uses periods of 50 to 210 cycles, including a stretch that drifts by about 5 percent. Silence is only ever held for 600 cycles, which is well past the timeout. Select changes are applied only at falling clock edges in the middle of a window, so the capture rule can be observed.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic {
    PM_IDLE = 1'b0,
    PM_RUN  = 1'b1
  } pm_state_e;

  // Effective window exponent: requested value saturated at the limit.
  function automatic int unsigned pm_clamp_sel(input int unsigned req,
                                               input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // Integer part of the mean: the binary point sits at bit position sel.
  function automatic longint unsigned pm_mean(input longint unsigned sum,
                                              input int unsigned sel);
    return sum >> sel;
  endfunction

  // Number of input periods in one window.
  function automatic int unsigned pm_periods(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its delayed copy
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/pm_gap_timer.sv
module pm_gap_timer #(
  parameter int TIMEOUT_CYC = 512,
  localparam int GAP_W = $clog2(TIMEOUT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic timeout_o,
  output logic nosig_o
);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(TIMEOUT_CYC - 1);

  logic [GAP_W-1:0] gap_q;

  assign timeout_o = !rise_i && (gap_q == GAP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      nosig_o <= 1'b0;
    end else begin
      if (rise_i) begin
        gap_q   <= '0;
        nosig_o <= 1'b0;
      end else begin
        if (gap_q != GAP_LAST) gap_q <= gap_q + 1'b1;
        if (timeout_o)         nosig_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_window.sv
module pm_window
  import pm_pkg::*;
#(
  parameter int ACC_W  = 18,
  parameter int SELL_W = 4,
  parameter int PCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              timeout_i,
  input  logic [SELL_W-1:0] sel_i,
  output logic              close_o,
  output logic [ACC_W-1:0]  win_sum_o,
  output logic [SELL_W-1:0] win_sel_o
);
  pm_state_e         state_q;
  logic [ACC_W-1:0]  acc_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [SELL_W-1:0] sel_q;
  logic [PCNT_W-1:0] pcnt_next;
  logic [PCNT_W-1:0] target;

  assign pcnt_next = pcnt_q + 1'b1;
  assign target    = PCNT_W'(pm_periods(32'(sel_q)));
  assign close_o   = (state_q == PM_RUN) && rise_i && (pcnt_next == target);
  assign win_sum_o = acc_q + 1'b1;
  assign win_sel_o = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_IDLE;
      acc_q   <= '0;
      pcnt_q  <= '0;
      sel_q   <= '0;
    end else if (timeout_i) begin
      state_q <= PM_IDLE;
    end else if (rise_i) begin
      if (state_q == PM_IDLE || close_o) begin
        state_q <= PM_RUN;
        acc_q   <= '0;
        pcnt_q  <= '0;
        sel_q   <= sel_i;
      end else begin
        acc_q  <= acc_q + 1'b1;
        pcnt_q <= pcnt_next;
      end
    end else if (state_q == PM_RUN) begin
      acc_q <= acc_q + 1'b1;
    end
  end
endmodule

// File: rtl/pm_post.sv
module pm_post
  import pm_pkg::*;
#(
  parameter int ACC_W  = 18,
  parameter int SELL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_i,
  input  logic [ACC_W-1:0]  sum_i,
  input  logic [SELL_W-1:0] sel_i,
  output logic [ACC_W-1:0]  sum_o,
  output logic [ACC_W-1:0]  mean_o,
  output logic [SELL_W-1:0] sel_o,
  output logic              valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o   <= '0;
      sel_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= close_i;
      if (close_i) begin
        sum_o <= sum_i;
        sel_o <= sel_i;
      end
    end
  end

  assign mean_o = ACC_W'(pm_mean(64'(sum_o), 32'(sel_o)));
endmodule

// File: rtl/period_meter.sv
module period_meter
  import pm_pkg::*;
#(
  parameter int LOG2N_MAX   = 8,
  parameter int TIMEOUT_CYC = 512,
  parameter int SEL_W       = 4,
  localparam int ACC_W  = $clog2(TIMEOUT_CYC + 1) + LOG2N_MAX,
  localparam int SELL_W = $clog2(LOG2N_MAX + 1),
  localparam int PCNT_W = LOG2N_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_i,
  input  logic [SEL_W-1:0] log2n_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [ACC_W-1:0] mean_o,
  output logic             valid_o,
  output logic             nosig_o
);
  logic              rise_w;
  logic              timeout_w;
  logic              close_w;
  logic [ACC_W-1:0]  win_sum_w;
  logic [SELL_W-1:0] win_sel_w;
  logic [SELL_W-1:0] post_sel_w;
  logic [SELL_W-1:0] sel_eff_w;

  assign sel_eff_w = SELL_W'(pm_clamp_sel(32'(log2n_i), LOG2N_MAX));

  pm_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .rise_o(rise_w)
  );

  pm_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .timeout_o(timeout_w), .nosig_o(nosig_o)
  );

  pm_window #(.ACC_W(ACC_W), .SELL_W(SELL_W), .PCNT_W(PCNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .timeout_i(timeout_w),
    .sel_i(sel_eff_w), .close_o(close_w),
    .win_sum_o(win_sum_w), .win_sel_o(win_sel_w)
  );

  pm_post #(.ACC_W(ACC_W), .SELL_W(SELL_W)) u_post (
    .clk(clk), .rst_n(rst_n), .close_i(close_w),
    .sum_i(win_sum_w), .sel_i(win_sel_w),
    .sum_o(sum_o), .mean_o(mean_o), .sel_o(post_sel_w), .valid_o(valid_o)
  );
endmodule

// File: rtl/period_meter_chk.sv
module period_meter_chk #(
  parameter int ACC_W       = 18,
  parameter int SELL_W      = 4,
  parameter int TIMEOUT_CYC = 512,
  parameter int LOG2N_MAX   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_w,
  input logic              timeout_w,
  input logic              close_w,
  input logic [SELL_W-1:0] post_sel_w,
  input logic [ACC_W-1:0]  sum_o,
  input logic              valid_o,
  input logic              nosig_o
);
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rise_w));

  assert_sum_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(sum_o));

  assert_sum_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sum_o <= (ACC_W'(TIMEOUT_CYC) << post_sel_w)));

  assert_sum_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sum_o >= (ACC_W'(2) << post_sel_w)));

  assert_sel_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (post_sel_w <= SELL_W'(LOG2N_MAX)));

  assert_nosig_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nosig_o) |-> $past(timeout_w));

  assert_nosig_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> !nosig_o);

  assert_no_close_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    close_w |-> !nosig_o);
endmodule

bind period_meter period_meter_chk #(
  .ACC_W(ACC_W), .SELL_W(SELL_W), .TIMEOUT_CYC(TIMEOUT_CYC), .LOG2N_MAX(LOG2N_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_w(rise_w), .timeout_w(timeout_w),
  .close_w(close_w), .post_sel_w(post_sel_w), .sum_o(sum_o),
  .valid_o(valid_o), .nosig_o(nosig_o)
);

// File: tb/period_meter_bench.sv
`timescale 1ns/1ps
module period_meter_bench;
  localparam int T = 512;
  localparam int LMAX = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_i = 1'b0;
  logic [3:0]  log2n_i = 4'd0;
  logic [17:0] sum_o, mean_o;
  logic        valid_o, nosig_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  period_meter u_period_meter (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .log2n_i(log2n_i),
    .sum_o(sum_o), .mean_o(mean_o), .valid_o(valid_o), .nosig_o(nosig_o)
  );

  // Behavioural reference model
  int  hist[$];
  bit  m_run, m_valid, m_nosig;
  int  m_elapsed, m_periods, m_sel, m_gap, m_sum, m_psel;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      m_run = 0; m_valid = 0; m_nosig = 0;
      m_elapsed = 0; m_periods = 0; m_sel = 0; m_gap = 0; m_sum = 0; m_psel = 0;
    end else begin
      bit r, to;
      r = (hist[1] == 1) && (hist[2] == 0);
      hist.push_front(int'(sig_i));
      void'(hist.pop_back());
      to = !r && (m_gap == T - 1);
      m_valid = 0;
      if (r) begin
        m_nosig = 0; m_gap = 0;
        if (!m_run) begin
          m_run = 1; m_elapsed = 0; m_periods = 0;
          m_sel = (int'(log2n_i) > LMAX) ? LMAX : int'(log2n_i);
        end else begin
          m_elapsed++; m_periods++;
          if (m_periods == (1 << m_sel)) begin
            m_sum = m_elapsed; m_psel = m_sel; m_valid = 1;
            m_elapsed = 0; m_periods = 0;
            m_sel = (int'(log2n_i) > LMAX) ? LMAX : int'(log2n_i);
          end
        end
      end else begin
        if (m_gap != T - 1) m_gap++;
        if (to) begin m_nosig = 1; m_run = 0; end
        else if (m_run) m_elapsed++;
      end
    end
  end

  // Per-cycle comparison and capture of posted results
  int psum[$];
  int pmean[$];
  int vcount = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (valid_o !== m_valid) begin
        fails++; $display("FAIL R5 valid_o actual=%0b expected=%0b", valid_o, m_valid);
      end
      checks++;
      if (int'(sum_o) != m_sum) begin
        fails++; $display("FAIL R4 sum_o actual=%0d expected=%0d", sum_o, m_sum);
      end
      checks++;
      if (int'(mean_o) != (m_sum >> m_psel)) begin
        fails++; $display("FAIL R9 mean_o actual=%0d expected=%0d", mean_o, m_sum >> m_psel);
      end
      checks++;
      if (nosig_o !== m_nosig) begin
        fails++; $display("FAIL R10 nosig_o actual=%0b expected=%0b", nosig_o, m_nosig);
      end
      if (valid_o) begin
        psum.push_back(int'(sum_o)); pmean.push_back(int'(mean_o)); vcount++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic train(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      sig_i = 1'b1; repeat (p / 2) @(negedge clk);
      sig_i = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic quiet();
    sig_i = 1'b0; repeat (600) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int base;
    repeat (4) @(negedge clk);
    // R1: outputs cleared under reset
    chk(valid_o == 0 && nosig_o == 0, "R1 flags", int'(valid_o) + int'(nosig_o), 0);
    chk(sum_o == 0 && mean_o == 0, "R1 data", int'(sum_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 0 && sum_o == 0, "R1 after release", int'(sum_o), 0);

    // R3: first edge only opens a window
    log2n_i = 4'd0;
    train(100, 1);
    chk(vcount == 0, "R3 no post on opening edge", vcount, 0);

    // R2: closing rise seen at the third rising clock edge
    sig_i = 1'b1; n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (valid_o) break;
    end
    chk(n == 3, "R2 edge-to-valid latency", n, 3);
    chk(int'(sum_o) == 100, "R4 single period sum", int'(sum_o), 100);
    repeat (50) @(negedge clk);
    quiet();
    chk(nosig_o == 1, "R10 timeout raises flag", int'(nosig_o), 1);

    // R6: back-to-back windows of four periods
    log2n_i = 4'd2; base = vcount;
    train(120, 9);
    chk(vcount - base == 2, "R6 two windows posted", vcount - base, 2);
    chk(psum[$] == 480 && psum[$-1] == 480, "R6 contiguous sums", psum[$], 480);
    chk(pmean[$] == 120, "R9 mean of 4 periods", pmean[$], 120);
    quiet();

    // R11 and R7: flag clears on edge; select captured at window start
    log2n_i = 4'd1; base = vcount;
    train(60, 1);
    chk(nosig_o == 0, "R11 flag cleared by edge", int'(nosig_o), 0);
    log2n_i = 4'd3;
    train(60, 10);
    chk(vcount - base == 2, "R7 windows posted", vcount - base, 2);
    chk(psum[$-1] == 120, "R7 old select kept", psum[$-1], 120);
    chk(psum[$] == 480, "R7 new select applied", psum[$], 480);
    chk(pmean[$] == 60, "R9 mean after select change", pmean[$], 60);
    quiet();

    // R4: drifting periods, two periods per window
    log2n_i = 4'd1; base = vcount;
    train(190, 1); train(200, 1); train(210, 1); train(200, 2);
    chk(vcount - base == 2, "R4 drift windows", vcount - base, 2);
    chk(psum[$-1] == 390, "R4 drift first sum", psum[$-1], 390);
    chk(psum[$] == 410, "R4 drift second sum", psum[$], 410);
    quiet();

    // R8: oversized select saturates at 256 periods
    log2n_i = 4'd12; base = vcount;
    train(50, 257);
    chk(vcount - base == 1, "R8 one window", vcount - base, 1);
    chk(psum[$] == 12800, "R8 saturated sum", psum[$], 12800);
    chk(pmean[$] == 50, "R8 saturated mean", pmean[$], 50);

    repeat (5) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule